// File: doc/BRIEF.md
# SPI FIFO Status and Interrupt Controller

This block sits next to the transmit and receive FIFOs of an SPI engine and turns their fill levels and event pulses into status flags, one interrupt line and two DMA request lines. It receives the current TX and RX entry counts, a vector of single-cycle event pulses from the engine, and the engine's busy level. It exposes a small word-addressed register port through which software or a bus adapter sets watermarks, interrupt and DMA enables, and the module enable, and issues FIFO flush commands.

Two kinds of flag exist. The data-request flags follow the FIFO levels: they are recomputed every cycle against the programmed watermarks and are never sticky. The event flags latch a pulse and hold it until a one is written to the same bit of the status word. The interrupt output combines the status word with an enable word that uses the same bit positions, so one mask covers both kinds of flag.

Register addresses (3-bit `addr`): 0 control, 1 status, 2 interrupt enable, 3 DMA enable, 4 watermarks, 5 FIFO levels, 6 receive status, 7 geometry. Writes take effect at the clock edge on which `wr_en` is high; reads are combinational from `addr`.

Top module: `spi_fifo_stat_ctl`

## Requirements
- R1: While `rst_n` is low every stored setting and flag is zero, so all outputs are low and every register except geometry, levels and receive status reads zero.
- R2: Status bit 0 (TX request) reads one in the cycle after a clock edge at which `tx_count` was less than or equal to the TX watermark, and zero otherwise.
- R3: Status bit 1 (RX ready) reads one in the cycle after a clock edge at which `rx_count` was greater than the RX watermark, and zero otherwise.
- R4: Status bits 13:8 latch `evt_i[5:0]` (bit 9 is frame complete, bit 10 is transfer complete); a set bit stays set until a status write with a one in that bit position, a zero in the written bit leaves it unchanged, and a pulse in the same cycle as the clearing write leaves the bit set.
- R5: Status bit 24 (busy) reads the value `engine_busy` had at the previous clock edge; status writes have no effect on it.
- R6: The interrupt-enable register stores only bits 0, 1 and 13:8 (other bits read zero), and `irq` is high exactly when some status bit and the enable bit at the same position are both one.
- R7: DMA-enable bit 0 drives `tx_dma_req` as the AND with status bit 0, and bit 1 drives `rx_dma_req` as the AND with status bit 1; other bits read zero.
- R8: Control bit 0 is stored and drives `mod_en`; writing a one to control bit 8 gives a single-cycle `tx_flush` pulse in the following cycle, and a one in bit 9 gives a `rx_flush` pulse likewise; bits 8 and 9 read back as zero.
- R9: The watermark register holds the TX watermark in bits TX_LOG2-1:0 and the RX watermark in bits 16+RX_LOG2-1:16; other bits read zero.
- R10: The level register reads `tx_count` in bits 7:0 and `rx_count` in bits 23:16, zero elsewhere.
- R11: The geometry register reads TX_LOG2 in bits 3:0 and RX_LOG2 in bits 11:8 and ignores writes.
- R12: The receive-status register reads one in bit 1 while `rx_count` is zero, and zero in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register index for read and write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` |
| tx_count | input | TX_LOG2+1 | Entries held in the TX FIFO |
| rx_count | input | RX_LOG2+1 | Entries held in the RX FIFO |
| evt_i | input | 6 | Event pulses for status bits 13:8 |
| engine_busy | input | 1 | Engine busy level |
| irq | output | 1 | Combined interrupt |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| mod_en | output | 1 | Module enable |
| tx_flush | output | 1 | TX FIFO flush pulse |
| rx_flush | output | 1 | RX FIFO flush pulse |

## Verification
The assertions watch on every cycle that an event pulse lands in its sticky bit and stays there until a clearing write, that busy tracks the engine one cycle late, that an empty TX FIFO always raises the TX request and an empty RX FIFO never raises RX ready, that DMA requests appear only with their flag, that a zero enable word silences the interrupt, and that a flush write yields its pulse. The exact watermark comparisons at and around the thresholds, the masking of the enable word, the read-back of every register, the immunity of geometry and busy to writes, and the set-wins-over-clear collision are shown only by the bench's scenarios compared against its reference model.

// File: rtl/spi_fsc_pkg.sv
package spi_fsc_pkg;

    typedef enum logic [2:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_IEN   = 3'd2,
        A_DMA   = 3'd3,
        A_WMARK = 3'd4,
        A_LEVEL = 3'd5,
        A_RXST  = 3'd6,
        A_GEOM  = 3'd7
    } reg_addr_e;

    localparam int N_EVT      = 6;
    localparam int B_TXREQ    = 0;
    localparam int B_RXRDY    = 1;
    localparam int B_EVT_LO   = 8;
    localparam int B_BUSY     = 24;
    localparam int B_EN       = 0;
    localparam int B_TXFL     = 8;
    localparam int B_RXFL     = 9;
    localparam int RX_WM_LSB  = 16;
    localparam int RX_LVL_LSB = 16;
    localparam int B_RXEMPTY  = 1;

    localparam logic [31:0] IEN_MASK = 32'h0000_3F03;

endpackage

// File: rtl/spi_fsc_level.sv
module spi_fsc_level #(
    parameter int CW    = 5,
    parameter int WW    = 4,
    parameter bit ABOVE = 1'b0
) (
    input  logic [CW-1:0] count,
    input  logic [WW-1:0] wmark,
    output logic          flag
);
    logic [CW-1:0] wm_ext;
    assign wm_ext = CW'(wmark);

    generate
        if (ABOVE) begin : g_above
            assign flag = (count > wm_ext);
        end else begin : g_at_or_below
            assign flag = (count <= wm_ext);
        end
    endgenerate
endmodule

// File: rtl/spi_fsc_events.sv
module spi_fsc_events #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    logic [N-1:0] flag_d, flag_q;

    generate
        for (genvar gi = 0; gi < N; gi++) begin : g_bit
            // a new pulse takes priority over a clearing write
            always_comb flag_d[gi] = set_i[gi] | (flag_q[gi] & ~clr_i[gi]);
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flags_o = flag_q;
endmodule

// File: rtl/spi_fifo_stat_ctl.sv
module spi_fifo_stat_ctl
    import spi_fsc_pkg::*;
#(
    parameter  int TX_LOG2 = 4,
    parameter  int RX_LOG2 = 4,
    localparam int TX_CW   = TX_LOG2 + 1,
    localparam int RX_CW   = RX_LOG2 + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rd_data,
    input  logic [TX_CW-1:0] tx_count,
    input  logic [RX_CW-1:0] rx_count,
    input  logic [5:0]       evt_i,
    input  logic             engine_busy,
    output logic             irq,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             mod_en,
    output logic             tx_flush,
    output logic             rx_flush
);
    typedef struct packed {
        logic               en;
        logic [31:0]        ien;
        logic [1:0]         dma;
        logic [TX_LOG2-1:0] txwm;
        logic [RX_LOG2-1:0] rxwm;
        logic               txreq;
        logic               rxrdy;
        logic               busy;
        logic               txfl;
        logic               rxfl;
    } state_t;

    state_t s_d, s_q;

    reg_addr_e        ra;
    logic             tx_lvl, rx_lvl;
    logic [N_EVT-1:0] evt_clr, evt_q;
    logic [31:0]      stat_w, ien_w;
    logic             unused_wdata;

    assign ra           = reg_addr_e'(addr);
    assign unused_wdata = ^wdata;

    spi_fsc_level #(.CW(TX_CW), .WW(TX_LOG2), .ABOVE(1'b0)) u_tx_lvl (
        .count(tx_count), .wmark(s_q.txwm), .flag(tx_lvl)
    );

    spi_fsc_level #(.CW(RX_CW), .WW(RX_LOG2), .ABOVE(1'b1)) u_rx_lvl (
        .count(rx_count), .wmark(s_q.rxwm), .flag(rx_lvl)
    );

    assign evt_clr = (wr_en && ra == A_STAT) ? wdata[B_EVT_LO +: N_EVT] : '0;

    spi_fsc_events #(.N(N_EVT)) u_evt (
        .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(evt_clr), .flags_o(evt_q)
    );

    always_comb begin
        s_d       = s_q;
        s_d.txreq = tx_lvl;
        s_d.rxrdy = rx_lvl;
        s_d.busy  = engine_busy;
        s_d.txfl  = 1'b0;
        s_d.rxfl  = 1'b0;
        if (wr_en) begin
            case (ra)
                A_CTRL: begin
                    s_d.en   = wdata[B_EN];
                    s_d.txfl = wdata[B_TXFL];
                    s_d.rxfl = wdata[B_RXFL];
                end
                A_IEN:   s_d.ien = wdata & IEN_MASK;
                A_DMA:   s_d.dma = wdata[1:0];
                A_WMARK: begin
                    s_d.txwm = wdata[TX_LOG2-1:0];
                    s_d.rxwm = wdata[RX_WM_LSB +: RX_LOG2];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        stat_w                      = '0;
        stat_w[B_TXREQ]             = s_q.txreq;
        stat_w[B_RXRDY]             = s_q.rxrdy;
        stat_w[B_EVT_LO +: N_EVT]   = evt_q;
        stat_w[B_BUSY]              = s_q.busy;
    end

    assign ien_w = s_q.ien;

    always_comb begin
        rd_data = '0;
        case (ra)
            A_CTRL:  rd_data[B_EN] = s_q.en;
            A_STAT:  rd_data = stat_w;
            A_IEN:   rd_data = s_q.ien;
            A_DMA:   rd_data[1:0] = s_q.dma;
            A_WMARK: begin
                rd_data[TX_LOG2-1:0]          = s_q.txwm;
                rd_data[RX_WM_LSB +: RX_LOG2] = s_q.rxwm;
            end
            A_LEVEL: begin
                rd_data[TX_CW-1:0]           = tx_count;
                rd_data[RX_LVL_LSB +: RX_CW] = rx_count;
            end
            A_RXST:  rd_data[B_RXEMPTY] = (rx_count == '0);
            A_GEOM:  begin
                rd_data[3:0]  = 4'(TX_LOG2);
                rd_data[11:8] = 4'(RX_LOG2);
            end
            default: ;
        endcase
    end

    assign irq        = |(stat_w & s_q.ien);
    assign tx_dma_req = s_q.dma[0] & s_q.txreq;
    assign rx_dma_req = s_q.dma[1] & s_q.rxrdy;
    assign mod_en     = s_q.en;
    assign tx_flush   = s_q.txfl;
    assign rx_flush   = s_q.rxfl;
endmodule

// File: rtl/spi_fsc_chk.sv
module spi_fsc_chk #(
    parameter int TX_CW = 5,
    parameter int RX_CW = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       addr,
    input logic [31:0]      wdata,
    input logic [TX_CW-1:0] tx_count,
    input logic [RX_CW-1:0] rx_count,
    input logic [5:0]       evt_i,
    input logic             engine_busy,
    input logic             irq,
    input logic             tx_dma_req,
    input logic             rx_dma_req,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic [31:0]      status,
    input logic [31:0]      ien
);
    // R2
    tx_empty_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_count == '0) |=> status[0]);

    // R3
    rx_empty_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_count == '0) |=> !status[1]);

    // R4
    frame_evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i[1] |=> status[9]);

    // R4
    frame_evt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status[9] && !(wr_en && addr == 3'd1 && wdata[9])) |=> status[9]);

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        engine_busy |=> status[24]);

    // R5
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !engine_busy |=> !status[24]);

    // R6
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);

    // R7
    tx_dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_dma_req |-> status[0]);

    // R7
    rx_dma_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_dma_req |-> status[1]);

    // R8
    tx_flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata[8]) |=> tx_flush);

    // R8
    rx_flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd0 && wdata[9]) |=> rx_flush);
endmodule

bind spi_fifo_stat_ctl spi_fsc_chk #(.TX_CW(TX_CW), .RX_CW(RX_CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .tx_count(tx_count), .rx_count(rx_count), .evt_i(evt_i),
    .engine_busy(engine_busy), .irq(irq), .tx_dma_req(tx_dma_req),
    .rx_dma_req(rx_dma_req), .tx_flush(tx_flush), .rx_flush(rx_flush),
    .status(stat_w), .ien(ien_w)
);

// File: tb/spi_fifo_stat_ctl_test.sv
module spi_fifo_stat_ctl_test;
    localparam int TXL = 4;
    localparam int RXL = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic [31:0] rd_data;
    logic [4:0]  tx_count, rx_count;
    logic [5:0]  evt_i;
    logic        engine_busy;
    logic        irq, tx_dma_req, rx_dma_req, mod_en, tx_flush, rx_flush;

    always #5 clk = ~clk;

    spi_fifo_stat_ctl #(.TX_LOG2(TXL), .RX_LOG2(RXL)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rd_data(rd_data), .tx_count(tx_count), .rx_count(rx_count),
        .evt_i(evt_i), .engine_busy(engine_busy), .irq(irq),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .mod_en(mod_en),
        .tx_flush(tx_flush), .rx_flush(rx_flush)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    // behavioural reference state
    int m_en, m_ien, m_dma, m_txwm, m_rxwm, m_txreq, m_rxrdy, m_busy, m_txfl, m_rxfl, m_evt;

    always @(posedge clk) begin
        int clr;
        if (!rst_n) begin
            m_en = 0; m_ien = 0; m_dma = 0; m_txwm = 0; m_rxwm = 0;
            m_txreq = 0; m_rxrdy = 0; m_busy = 0; m_txfl = 0; m_rxfl = 0; m_evt = 0;
        end else begin
            clr = (wr_en && addr == 3'd1) ? int'((wdata >> 8) & 32'h3F) : 0;
            m_evt   = (int'(evt_i) | (m_evt & ~clr)) & 63;
            m_txreq = (int'(tx_count) <= m_txwm) ? 1 : 0;
            m_rxrdy = (int'(rx_count) > m_rxwm) ? 1 : 0;
            m_busy  = engine_busy ? 1 : 0;
            m_txfl  = 0;
            m_rxfl  = 0;
            if (wr_en) begin
                case (addr)
                    3'd0: begin
                        m_en = int'(wdata[0]); m_txfl = int'(wdata[8]); m_rxfl = int'(wdata[9]);
                    end
                    3'd2: m_ien = int'(wdata & 32'h3F03);
                    3'd3: m_dma = int'(wdata & 32'h3);
                    3'd4: begin
                        m_txwm = int'(wdata & 32'hF);
                        m_rxwm = int'((wdata >> 16) & 32'hF);
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] m_stat();
        return 32'(m_txreq | (m_rxrdy << 1) | (m_evt << 8) | (m_busy << 24));
    endfunction

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            3'd0: return 32'(m_en);
            3'd1: return m_stat();
            3'd2: return 32'(m_ien);
            3'd3: return 32'(m_dma);
            3'd4: return 32'(m_txwm | (m_rxwm << 16));
            3'd5: return 32'(int'(tx_count) | (int'(rx_count) << 16));
            3'd6: return (rx_count == 0) ? 32'h2 : 32'h0;
            default: return 32'(TXL | (RXL << 8));
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h (t=%0t addr=%0d)", tag, act, exp, $time, addr);
        end
    endtask

    task automatic compare_all();
        logic [31:0] e;
        string t;
        bit r;
        r = !rst_n;
        e = m_read(addr);
        chk(r ? "R1" : "R6", 32'(irq), 32'((m_stat() & 32'(m_ien)) != 0));
        chk(r ? "R1" : "R7", 32'(tx_dma_req), 32'((m_dma & 1) & m_txreq));
        chk(r ? "R1" : "R7", 32'(rx_dma_req), 32'(((m_dma >> 1) & 1) & m_rxrdy));
        chk(r ? "R1" : "R8", {29'b0, mod_en, tx_flush, rx_flush},
            32'((m_en << 2) | (m_txfl << 1) | m_rxfl));
        if (addr == 3'd1 && !r) begin
            chk("R2", 32'(rd_data[0]), 32'(e[0]));
            chk("R3", 32'(rd_data[1]), 32'(e[1]));
            chk("R4", 32'(rd_data[13:8]), 32'(e[13:8]));
            chk("R5", 32'(rd_data[24]), 32'(e[24]));
            chk("R1", rd_data & 32'hFEFF_C0FC, 32'h0);
        end else begin
            case (addr)
                3'd0: t = "R8";
                3'd1: t = "R1";
                3'd2: t = "R6";
                3'd3: t = "R7";
                3'd4: t = "R9";
                3'd5: t = "R10";
                3'd6: t = "R12";
                default: t = "R11";
            endcase
            if (r && addr < 3'd5) t = "R1";
            chk(t, rd_data, e);
        end
    endtask

    task automatic step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        step();
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a);
        addr = a;
        step();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; addr = '0; wdata = '0;
        tx_count = '0; rx_count = '0; evt_i = '0; engine_busy = 1'b0;
        // R1: reset state across every register
        for (int a = 0; a < 8; a++) begin
            if (a == 2) wdata = 32'hFFFF_FFFF;
            rd(3'(a));
        end
        wdata = '0;
        rst_n = 1'b1;
        for (int a = 0; a < 8; a++) rd(3'(a));

        // R9: watermark layout
        wr(3'd4, 32'hFFF2_FFF3);
        rd(3'd4);
        // R2 R3 R10 R12: sweep levels around thresholds
        for (int i = 0; i < 40; i++) begin
            tx_count = 5'((i * 5) % 17);
            rx_count = 5'((i * 7) % 17);
            rd(3'((i % 3 == 0) ? 5 : ((i % 3 == 1) ? 1 : 6)));
        end
        for (int v = 0; v < 6; v++) begin
            tx_count = 5'(v); rx_count = 5'(v);
            rd(3'd1);
        end
        wr(3'd4, 32'h000F_0000);
        for (int v = 0; v < 17; v++) begin
            tx_count = 5'(v); rx_count = 5'(v);
            rd(3'd1);
        end

        // R6: enable mask
        wr(3'd2, 32'hFFFF_FFFF);
        rd(3'd2);
        wr(3'd2, 32'h0000_0200);
        rd(3'd1);
        // R4: frame pulse, zero write, clearing write
        evt_i = 6'b000010; rd(3'd1); evt_i = '0;
        rd(3'd1);
        wr(3'd1, 32'h0000_0000);
        rd(3'd1);
        wr(3'd1, 32'hFFFF_FBFF & 32'h0000_0200);
        rd(3'd1);
        // R4: set and clear in same cycle
        evt_i = 6'b000100;
        wr(3'd1, 32'h0000_0400);
        evt_i = '0;
        rd(3'd1);
        wr(3'd2, 32'h0000_0400);
        rd(3'd1);
        wr(3'd1, 32'h0000_3F00);
        for (int b = 0; b < 6; b++) begin
            evt_i = 6'(1 << b); rd(3'd1);
        end
        evt_i = '0;
        wr(3'd2, 32'h0000_2000);
        wr(3'd1, 32'h0000_1F00);
        rd(3'd1);
        wr(3'd1, 32'h0000_2000);
        rd(3'd1);

        // R5: busy follows and ignores writes
        engine_busy = 1'b1; rd(3'd1); rd(3'd1);
        wr(3'd1, 32'hFFFF_FFFF);
        rd(3'd1);
        engine_busy = 1'b0; rd(3'd1); rd(3'd1);

        // R6 R7: level flags to irq and DMA
        wr(3'd4, 32'h0003_0002);
        wr(3'd2, 32'h0000_0003);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd3);
        for (int i = 0; i < 12; i++) begin
            tx_count = 5'(i % 6); rx_count = 5'((i * 3) % 8);
            rd(3'd1);
        end
        wr(3'd3, 32'h0000_0002);
        tx_count = 5'd0; rx_count = 5'd0; rd(3'd3);
        rx_count = 5'd9; rd(3'd1); rd(3'd1);
        wr(3'd2, 32'h0);
        rd(3'd1);

        // R8: enable and flush pulses
        wr(3'd0, 32'h0000_0301);
        rd(3'd0); rd(3'd0);
        wr(3'd0, 32'h0000_0100);
        rd(3'd0);
        wr(3'd0, 32'h0000_0200);
        wr(3'd0, 32'h0000_0001);
        rd(3'd0);
        wr(3'd0, 32'h0);
        rd(3'd0);

        // R11: geometry ignores writes
        wr(3'd7, 32'hFFFF_FFFF);
        rd(3'd7);
        // R12: receive empty
        rx_count = 5'd0; rd(3'd6);
        rx_count = 5'd16; rd(3'd6);
        rx_count = 5'd1; rd(3'd6);

        finished = 1;
        summary();
        $finish;
    end
endmodule